// File: doc/BRIEF.md
# Multi-Comparator Event Timer

The block holds a 64-bit main counter that advances by one on every cycle where the clock-enable tick is high and the global enable is set. Several comparator channels watch the counter. When a channel's comparator equals the counter on a counting cycle, the channel sets its status bit. An enabled channel then drives its interrupt line until software clears that bit. A channel can fire once, or it can reload itself by adding a stored period on each match. A channel can also compare only the low 32 bits of the counter.

Software reaches the block through a flat 32-bit read/write port. Reads are combinational and have no side effects. Writes take effect at the clock edge where `req_i` and `we_i` are both high. A global legacy-routing bit moves channel 0 and channel 1 off their ordinary lines and onto two dedicated legacy outputs, one for the system tick and one for the real-time clock. Interrupt controllers, bus bridges and clock generation sit outside the block.

Top module: `evt_timer`

## Requirements
- R1: Offset 0x000 reads the capabilities word: bits [4:0] hold N_CHAN-1, bit 15 is the legacy-routing support flag (1), bits [31:16] hold the non-zero VENDOR_ID. Offset 0x004 reads PERIOD_FS, the tick length in femtoseconds, which lies between 100,000 and 100,000,000.
- R2: When global-config (offset 0x010) bit 0 is set, the counter rises by exactly one on each cycle with `tick_i` high and holds on each cycle with `tick_i` low. Its low word reads at 0xF0 and its high word at 0xF4.
- R3: While global bit 0 is clear, the counter holds its value whatever `tick_i` does.
- R4: Writes to 0xF0 and 0xF4 load the matching half of the counter only while global bit 0 is clear. While the counter runs they are ignored.
- R5: Channel n has its config at 0x100+0x20*n, with bit 0 enable, bit 1 periodic, bit 2 set-value, bit 3 32-bit mode and [8:4] route. Its comparator low word is at +0x08 and its high word at +0x0C. In one-shot mode, status bit n at 0x020 is set at the counting edge where the counter equals the comparator. The counter then reads comparator+1 and the channel does not fire again.
- R6: A one-shot comparator written with a value already behind the counter produces no interrupt until the compared counter bits come round to it again.
- R7: With periodic and set-value both set, the first comparator low write loads the match value and clears set-value. The next low write loads the period. High-word writes go to the same target as the low write that follows them. The channel then fires at match, match+period, match+2*period and so on.
- R8: In 32-bit mode only counter bits [31:0] are compared, while the counter itself keeps carrying into bits [63:32].
- R9: Status bits at 0x020 clear only when 1 is written to them, and writing 0 leaves them unchanged. A match sets the status bit even while the channel is disabled. `irq_o[n]` is high only while status n and channel enable n are both set.
- R10: With global bit 1 set, channel 0 drives `leg_tmr_o`, channel 1 drives `leg_rtc_o`, and `irq_o[0]` and `irq_o[1]` are held low. With global bit 1 clear, both legacy outputs stay low.
- R11: The channel config word reads back as written, with the route field [8:4] unchanged. The only exception is set-value, which reads 0 once the set-value sequence has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | N_CHAN | Per-channel interrupt levels |
| leg_tmr_o | output | 1 | Legacy tick interrupt (channel 0 when routed) |
| leg_rtc_o | output | 1 | Legacy clock interrupt (channel 1 when routed) |

## Verification
Some properties hold on every cycle, and the assertions check these continuously. The counter steps by exactly one on a counting cycle and stays put otherwise. A running counter cannot be written. Status bits fall only on a write-one-to-clear. The legacy-routing bit keeps channel 0 and channel 1 off either the ordinary lines or the legacy lines. The directed scenarios cover what depends on a programmed history and cannot be checked cycle by cycle: the exact count at which a one-shot fires, and the spacing of periodic matches after the two-write sequence. They also show a comparator set in the past staying silent, a 32-bit comparison firing across a carry into the high word, and the enable gating of the output.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned HALF_W = CNT_W / 2;

  localparam logic [CSR_AW-1:0] OFS_CAPS   = 12'h000;
  localparam logic [CSR_AW-1:0] OFS_PERIOD = 12'h004;
  localparam logic [CSR_AW-1:0] OFS_GCFG   = 12'h010;
  localparam logic [CSR_AW-1:0] OFS_ISR    = 12'h020;
  localparam logic [CSR_AW-1:0] OFS_CNT_LO = 12'h0F0;
  localparam logic [CSR_AW-1:0] OFS_CNT_HI = 12'h0F4;
  localparam int unsigned CH_BASE   = 'h100;
  localparam int unsigned CH_STRIDE = 'h20;
  localparam int unsigned CH_CFG    = 'h0;
  localparam int unsigned CH_CMP_LO = 'h8;
  localparam int unsigned CH_CMP_HI = 'hC;

  typedef struct packed {
    logic [4:0] route;
    logic       mode32;
    logic       setval;
    logic       periodic;
    logic       en;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);

  typedef struct packed {
    logic cfg;
    logic cmp_lo;
    logic cmp_hi;
  } ch_wr_t;

  function automatic logic [CSR_AW-1:0] ch_addr(input int unsigned ch, input int unsigned ofs);
    return CSR_AW'(CH_BASE + ch * CH_STRIDE + ofs);
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      // loads only while halted
      if (wr_lo_i) cnt_q[HALF_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  ch_wr_t            wr_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ch_cfg_t           cfg_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              stat_o
);
  ch_cfg_t          cfg_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  logic             per_next_q;
  logic             stat_q;
  logic             hit;
  logic             arm;

  assign hit = run_i && tick_i &&
               (cfg_q.mode32 ? (cnt_i[HALF_W-1:0] == cmp_q[HALF_W-1:0]) : (cnt_i == cmp_q));
  assign arm = cfg_q.setval && cfg_q.periodic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cmp_q      <= '0;
      per_q      <= '0;
      per_next_q <= 1'b0;
    end else begin
      if (hit && cfg_q.periodic) begin
        if (cfg_q.mode32) cmp_q[HALF_W-1:0] <= cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0];
        else              cmp_q             <= cmp_q + per_q;
      end
      if (wr_i.cfg) begin
        cfg_q      <= ch_cfg_t'(wdata_i[CFG_W-1:0]);
        per_next_q <= 1'b0;
      end else begin
        if (wr_i.cmp_hi) begin
          if (!arm && per_next_q) per_q[CNT_W-1:HALF_W] <= wdata_i;
          else                    cmp_q[CNT_W-1:HALF_W] <= wdata_i;
        end
        if (wr_i.cmp_lo) begin
          cfg_q.setval <= 1'b0;
          if (arm) begin
            cmp_q[HALF_W-1:0] <= wdata_i;
            per_next_q        <= 1'b1;
          end else if (per_next_q) begin
            per_q[HALF_W-1:0] <= wdata_i;
            per_next_q        <= 1'b0;
          end else begin
            cmp_q[HALF_W-1:0] <= wdata_i;
          end
        end
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 1'b0;
    else if (hit)   stat_q <= 1'b1;
    else if (clr_i) stat_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign cmp_o  = cmp_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
  parameter int unsigned N_CHAN = 3
) (
  input  logic [N_CHAN-1:0] stat_i,
  input  logic [N_CHAN-1:0] en_i,
  input  logic              leg_i,
  output logic [N_CHAN-1:0] irq_o,
  output logic              leg_tmr_o,
  output logic              leg_rtc_o
);
  logic [N_CHAN-1:0] live;

  assign live = stat_i & en_i;

  always_comb begin
    irq_o = live;
    if (leg_i) irq_o[1:0] = 2'b00;
  end

  assign leg_tmr_o = leg_i && live[0];
  assign leg_rtc_o = leg_i && live[1];
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned N_CHAN    = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic        LEG_SUP   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CHAN-1:0] irq_o,
  output logic              leg_tmr_o,
  output logic              leg_rtc_o
);
  localparam logic [31:0] CAPS = {VENDOR_ID, LEG_SUP, 10'd0, 5'(N_CHAN - 1)};

  logic              wr;
  logic              run_q;
  logic              leg_q;
  logic [CNT_W-1:0]  cnt_w;
  logic [N_CHAN-1:0] stat_w;
  logic [N_CHAN-1:0] en_w;
  logic [N_CHAN-1:0] clr_w;
  ch_cfg_t           cfg_a [N_CHAN];
  logic [CNT_W-1:0]  cmp_a [N_CHAN];

  assign wr    = req_i && we_i;
  assign clr_w = (wr && addr_i == OFS_ISR) ? wdata_i[N_CHAN-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr && addr_i == OFS_GCFG) begin
      run_q <= wdata_i[0];
      leg_q <= wdata_i[1] && LEG_SUP;
    end
  end

  evt_main_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick_i),
    .wr_lo_i (wr && addr_i == OFS_CNT_LO),
    .wr_hi_i (wr && addr_i == OFS_CNT_HI),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_w)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
    ch_wr_t ch_wr;
    assign ch_wr.cfg    = wr && addr_i == ch_addr(c, CH_CFG);
    assign ch_wr.cmp_lo = wr && addr_i == ch_addr(c, CH_CMP_LO);
    assign ch_wr.cmp_hi = wr && addr_i == ch_addr(c, CH_CMP_HI);

    evt_channel u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_q),
      .tick_i  (tick_i),
      .wr_i    (ch_wr),
      .wdata_i (wdata_i),
      .clr_i   (clr_w[c]),
      .cnt_i   (cnt_w),
      .cfg_o   (cfg_a[c]),
      .cmp_o   (cmp_a[c]),
      .stat_o  (stat_w[c])
    );
    assign en_w[c] = cfg_a[c].en;
  end

  evt_irq_route #(.N_CHAN(N_CHAN)) u_route (
    .stat_i    (stat_w),
    .en_i      (en_w),
    .leg_i     (leg_q),
    .irq_o     (irq_o),
    .leg_tmr_o (leg_tmr_o),
    .leg_rtc_o (leg_rtc_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CAPS:   rdata_o = CAPS;
      OFS_PERIOD: rdata_o = PERIOD_FS;
      OFS_GCFG:   rdata_o = {30'd0, leg_q, run_q};
      OFS_ISR:    rdata_o = 32'(stat_w);
      OFS_CNT_LO: rdata_o = cnt_w[HALF_W-1:0];
      OFS_CNT_HI: rdata_o = cnt_w[CNT_W-1:HALF_W];
      default: begin
        for (int c = 0; c < N_CHAN; c++) begin
          if (addr_i == ch_addr(c, CH_CFG))    rdata_o = 32'(cfg_a[c]);
          if (addr_i == ch_addr(c, CH_CMP_LO)) rdata_o = cmp_a[c][HALF_W-1:0];
          if (addr_i == ch_addr(c, CH_CMP_HI)) rdata_o = cmp_a[c][CNT_W-1:HALF_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int unsigned N_CHAN = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [11:0]       addr_i,
  input logic [31:0]       wdata_i,
  input logic [N_CHAN-1:0] irq_o,
  input logic              leg_tmr_o,
  input logic              leg_rtc_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              run_i,
  input logic              leg_i,
  input logic [N_CHAN-1:0] stat_i
);
  logic cnt_wr;
  logic isr_wr;
  assign cnt_wr = req_i && we_i && (addr_i == OFS_CNT_LO || addr_i == OFS_CNT_HI);
  assign isr_wr = req_i && we_i && addr_i == OFS_ISR;

  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  a_r3_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr) |=> $stable(cnt_i));

  a_r4_no_write_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_i));

  a_r10_legacy_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_i |-> (!irq_o[0] && !irq_o[1]));

  a_r10_legacy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !leg_i |-> (!leg_tmr_o && !leg_rtc_o));

  for (genvar k = 0; k < N_CHAN; k++) begin : g_k
    a_r9_w1c_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(stat_i[k]) |-> $past(isr_wr && wdata_i[k]));

    a_r9_irq_needs_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] |-> stat_i[k]);
  end
endmodule

bind evt_timer evt_timer_chk #(.N_CHAN(N_CHAN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .leg_tmr_o (leg_tmr_o),
  .leg_rtc_o (leg_rtc_o),
  .cnt_i     (cnt_w),
  .run_i     (run_q),
  .leg_i     (leg_q),
  .stat_i    (stat_w)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  localparam int N = 3;
  localparam logic [11:0] A_CAPS = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010,
                          A_ISR = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4;

  logic clk = 0, rst_n = 0, tick = 1, req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] irq;
  logic leg_tmr, leg_rtc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  evt_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .leg_tmr_o(leg_tmr), .leg_rtc_o(leg_rtc)
  );

  function automatic logic [11:0] ch(input int c, input int ofs);
    return 12'(32'h100 + c * 32'h20 + ofs);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic wait_sig(input int which, input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      case (which)
        0, 1, 2: seen = irq[which];
        3:       seen = leg_tmr;
        default: seen = leg_rtc;
      endcase
    end
  endtask

  task automatic halt_load(input logic [31:0] lo, input logic [31:0] hi);
    wr(A_GCFG, 0);
    wr(A_CLO, lo);
    wr(A_CHI, hi);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CAPS, d); chk("R1 caps", d, 32'hC0DE_8002);
    rd(A_PER, d);  chk("R1 period", d, 32'd10_000_000);
    rd(A_CLO, d);  chk("R2 counter at reset", d, 0);
    chk("R9 irq at reset", {irq, leg_tmr, leg_rtc}, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    repeat (4) @(negedge clk);
    rd(A_CLO, a); chk("R3 halted holds", a, 0);
    halt_load(32'h100, 32'h2);
    rd(A_CLO, a); chk("R4 load lo halted", a, 32'h100);
    rd(A_CHI, a); chk("R4 load hi halted", a, 32'h2);
    wr(A_GCFG, 1);
    rd(A_CLO, a);
    repeat (6) @(negedge clk);
    rd(A_CLO, b); chk("R2 steps per tick", b - a, 7);
    tick = 0;
    rd(A_CLO, a);
    repeat (6) @(negedge clk);
    rd(A_CLO, b); chk("R2 holds without tick", b, a);
    tick = 1;
    rd(A_CLO, a);
    wr(A_CLO, 0);
    rd(A_CLO, b); chk("R4 write ignored running", b - a, 3);
    wr(A_GCFG, 0);
    rd(A_CLO, a);
    repeat (5) @(negedge clk);
    rd(A_CLO, b); chk("R3 halted with ticks", b, a);
  endtask

  task automatic t_oneshot();
    logic [31:0] d; bit seen;
    halt_load(0, 0);
    wr(ch(2, 0), 32'h51);
    rd(ch(2, 0), d); chk("R11 cfg readback", d, 32'h51);
    wr(ch(2, 'hC), 0);
    wr(ch(2, 8), 40);
    wr(A_GCFG, 1);
    wait_sig(2, 200, seen);
    chk("R5 one-shot fires", seen, 1);
    peek(A_CLO, d); chk("R5 fire count", d, 41);
    wr(A_ISR, 32'h4);
    wait_sig(2, 100, seen);
    chk("R5 no refire", seen, 0);
  endtask

  task automatic t_past();
    logic [31:0] d; bit seen;
    halt_load(100, 0);
    wr(ch(2, 0), 32'h9);
    wr(ch(2, 8), 50);
    wr(A_ISR, 32'h7);
    wr(A_GCFG, 1);
    wait_sig(2, 200, seen);
    chk("R6 past comparator silent", seen, 0);
    rd(A_ISR, d); chk("R6 status clear", d[2], 0);
    halt_load(32'hFFFF_FFF0, 5);
    wr(ch(2, 8), 3);
    wr(A_GCFG, 1);
    wait_sig(2, 100, seen);
    chk("R6 fires after wrap", seen, 1);
    peek(A_CLO, d); chk("R8 low compare", d, 4);
    peek(A_CHI, d); chk("R8 carry into high", d, 6);
    wr(A_ISR, 32'h4);
  endtask

  task automatic t_periodic();
    logic [31:0] d; bit seen;
    halt_load(0, 0);
    wr(ch(2, 0), 0);
    wr(A_ISR, 32'h7);
    wr(ch(0, 0), 32'h7);
    wr(ch(0, 'hC), 0);
    wr(ch(0, 8), 20);
    wr(ch(0, 'hC), 0);
    wr(ch(0, 8), 10);
    rd(ch(0, 0), d); chk("R11 setval self-clears", d, 32'h3);
    rd(ch(0, 8), d); chk("R7 first match stored", d, 20);
    wr(A_GCFG, 1);
    for (int i = 0; i < 3; i++) begin
      wait_sig(0, 100, seen);
      chk("R7 periodic fire", seen, 1);
      peek(A_CLO, d); chk("R7 periodic spacing", d, 21 + 10 * i);
      wr(A_ISR, 32'h1);
    end
  endtask

  task automatic t_legacy();
    bit seen;
    wr(A_GCFG, 3);
    wait_sig(3, 40, seen);
    chk("R10 legacy tick routed", seen, 1);
    chk("R10 ordinary line masked", irq[0], 0);
    wr(A_GCFG, 1);
    chk("R10 returns to ordinary line", irq[0], 1);
    wr(A_ISR, 32'h1);
    wr(ch(0, 0), 0);
  endtask

  task automatic t_gate();
    logic [31:0] d; bit seen;
    halt_load(0, 0);
    wr(ch(1, 0), 0);
    wr(ch(1, 'hC), 0);
    wr(ch(1, 8), 15);
    wr(A_ISR, 32'h7);
    wr(A_GCFG, 1);
    wait_sig(1, 40, seen);
    chk("R9 disabled gives no irq", seen, 0);
    rd(A_ISR, d); chk("R9 status set while disabled", d[1], 1);
    wr(A_ISR, 0);
    rd(A_ISR, d); chk("R9 write zero keeps status", d[1], 1);
    wr(ch(1, 0), 1);
    chk("R9 enable exposes irq", irq[1], 1);
    wr(A_ISR, 32'h2);
    rd(A_ISR, d); chk("R9 w1c clears", d[1], 0);
    chk("R9 irq drops", irq[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_oneshot();
    t_past();
    t_periodic();
    t_legacy();
    t_gate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule